// File: doc/BRIEF.md
# Cascadable Parity Generator/Checker with Shared Parity Pin

This block computes odd parity over a data word and exchanges the parity bit with the rest of the system through a single bidirectional pin. A mode input selects the pin's role. In generate mode the block drives the computed bit onto the pin. In check mode it releases the pin, reads the bit another agent placed there, and pulls an active-low error line when that bit does not complete odd parity over the word.

The word is built from a parameterised number of stages. Each stage reduces nine inputs. The first stage takes nine data bits. Every later stage takes eight fresh data bits plus the partial sum handed on by the stage before it, so any number of stages covers 9 + 8·(STAGES−1) data bits. Only the last stage connects to the pin logic. The tri-state pad is modelled with separate output-value, output-enable and input signals. A single flop holds the pin released from reset until the first clock edge after reset ends, so the bus is never driven before the mode is settled.

Top module: `parity_io_unit`

## Requirements
- R1: `par_out` is the inverse of the XOR of all DATA_W data bits, so that the data bits plus `par_out` always hold an odd number of ones.
- R2: With `chk_en` = 0 (generate mode) and the block out of reset for at least one rising clock edge, `par_oe` is 1.
- R3: With `chk_en` = 1 (check mode), `par_oe` is 0.
- R4: In generate mode `err_n` is 1 for every data pattern and for both levels of `par_in`.
- R5: In check mode `err_n` is 0 when the data holds an even count of ones and `par_in` is 0, or an odd count and `par_in` is 1. Otherwise `err_n` is 1.
- R6: While `rst_n` is 0, `par_oe` is 0 and `err_n` is 1. After `rst_n` rises, `par_oe` stays 0 until the next rising edge of `clk`.
- R7: With STAGES = 2, data bits [8:0] feed the first stage and bits [16:9] feed the second, together with the first stage's partial sum. A word whose ones all sit in bits [16:9] obeys R1 and R5 exactly as a word with ones in bits [8:0] does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the pin-release flop |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_en | input | 1 | Mode: 0 generate and drive the pin, 1 check the pin |
| data | input | DATA_W | Data word, 9 + 8·(STAGES−1) bits |
| par_in | input | 1 | Level read back from the parity pin |
| par_out | output | 1 | Computed odd-parity bit for the pin |
| par_oe | output | 1 | Pin output enable, 1 = drive |
| err_n | output | 1 | Active-low parity error |

## Verification
Every one of the 512 patterns of the first stage's nine bits is applied in both modes and with both pin levels. The second stage's bits take a value derived from the pattern, so even and odd totals occur with every split between the two stages. Against a flat XOR reference, this shows whether the error polarity, the mode gating and the pin enable each react only to their proper inputs. A second sweep holds the first stage at zero and walks all 256 upper-byte values, so a broken link between stages cannot be hidden by activity in the low lane. Reset is applied at the start and again in the middle of the run, and the pin enable is sampled both before and after the first clock edge that follows release.

// File: rtl/parity_pkg.sv
package parity_pkg;

   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_CHK = 1'b1
   } par_mode_e;

   // nodes in level l of a pairwise reduction over w leaves
   function automatic int lvl_w(input int w, input int l);
      return (w + (1 << l) - 1) >> l;
   endfunction

   // flat offset of level l when all levels are packed back to back
   function automatic int lvl_off(input int w, input int l);
      int acc;
      acc = 0;
      for (int k = 0; k < l; k++) acc += lvl_w(w, k);
      return acc;
   endfunction

   function automatic int chain_w(input int lane_w, input int stages);
      return lane_w + (lane_w - 1) * (stages - 1);
   endfunction

endpackage

// File: rtl/parity_tree.sv
module parity_tree
   import parity_pkg::*;
#(
   parameter int W        = 9,
   parameter bit BALANCED = 1'b1
) (
   input  logic [W-1:0] bits,
   output logic         odd
);

   if (W < 2) begin : g_bad_w
      $error("parity_tree: W must be at least 2");
   end

   if (BALANCED) begin : g_bal
      localparam int LV    = $clog2(W);
      localparam int NODES = lvl_off(W, LV + 1);
      logic [NODES-1:0] node;

      assign node[W-1:0] = bits;
      for (genvar L = 1; L <= LV; L++) begin : g_lvl
         localparam int SRC  = lvl_off(W, L - 1);
         localparam int DST  = lvl_off(W, L);
         localparam int NIN  = lvl_w(W, L - 1);
         localparam int NOUT = lvl_w(W, L);
         for (genvar j = 0; j < NOUT; j++) begin : g_n
            if (2 * j + 1 < NIN) begin : g_pair
               assign node[DST+j] = node[SRC+2*j] ^ node[SRC+2*j+1];
            end else begin : g_pass
               assign node[DST+j] = node[SRC+2*j];
            end
         end
      end
      assign odd = node[NODES-1];
   end else begin : g_ripple
      logic [W-1:0] acc;
      assign acc[0] = bits[0];
      for (genvar i = 1; i < W; i++) begin : g_r
         assign acc[i] = acc[i-1] ^ bits[i];
      end
      assign odd = acc[W-1];
   end

endmodule

// File: rtl/parity_port_ctrl.sv
module parity_port_ctrl
   import parity_pkg::*;
(
   input  logic      sum,
   input  par_mode_e mode,
   input  logic      ready,
   input  logic      par_in,
   output logic      par_out,
   output logic      par_oe,
   output logic      err_n
);

   logic checking;

   assign checking = ready && (mode == MODE_CHK);
   assign par_out  = ~sum;
   assign par_oe   = ready && (mode == MODE_GEN);
   // word plus received bit must hold an odd count of ones
   assign err_n    = ~checking | (sum ^ par_in);

endmodule

// File: rtl/parity_io_unit.sv
module parity_io_unit
   import parity_pkg::*;
#(
   parameter  int LANE_W   = 9,
   parameter  int STAGES   = 2,
   parameter  bit BALANCED = 1'b1,
   localparam int DATA_W   = chain_w(LANE_W, STAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [DATA_W-1:0] data,
   input  logic              par_in,
   output logic              par_out,
   output logic              par_oe,
   output logic              err_n
);

   localparam int FRESH_W = LANE_W - 1;

   if (LANE_W < 2) begin : g_bad_lane
      $error("parity_io_unit: LANE_W must be at least 2");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("parity_io_unit: STAGES must be at least 1");
   end

   logic              ready;
   logic [STAGES-1:0] part;
   par_mode_e         mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ready <= 1'b0;
      else        ready <= 1'b1;
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic [LANE_W-1:0] lane;
      if (k == 0) begin : g_head
         assign lane = data[LANE_W-1:0];
      end else begin : g_link
         assign lane = {data[LANE_W + FRESH_W*(k-1) +: FRESH_W], part[k-1]};
      end
      parity_tree #(.W(LANE_W), .BALANCED(BALANCED)) u_tree (
         .bits (lane),
         .odd  (part[k])
      );
   end

   assign mode = par_mode_e'(chk_en);

   parity_port_ctrl u_port (
      .sum     (part[STAGES-1]),
      .mode    (mode),
      .ready   (ready),
      .par_in  (par_in),
      .par_out (par_out),
      .par_oe  (par_oe),
      .err_n   (err_n)
   );

endmodule

// File: rtl/parity_io_chk.sv
module parity_io_chk #(
   parameter int DATA_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chk_en,
   input logic [DATA_W-1:0] data,
   input logic              par_in,
   input logic              par_out,
   input logic              par_oe,
   input logic              err_n
);

   // R1 / R7: chained stages agree with a flat reduction of the whole word
   a_r1_odd_total: assert property (@(posedge clk) disable iff (!rst_n)
      par_out == ~(^data));

   a_r2_drive_gen: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !chk_en) |-> par_oe);

   a_r3_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> !par_oe);

   a_r4_quiet_gen: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_en |-> err_n);

   a_r5_err_rule: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && chk_en) |-> (err_n == ^{data, par_in}));

   a_r6_reset_hold: assert property (@(posedge clk)
      !rst_n |-> (!par_oe && err_n));

endmodule

bind parity_io_unit parity_io_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .chk_en  (chk_en),
   .data    (data),
   .par_in  (par_in),
   .par_out (par_out),
   .par_oe  (par_oe),
   .err_n   (err_n)
);

// File: tb/parity_io_unit_tb_top.sv
module parity_io_unit_tb_top;

   localparam int LANE_W = 9;
   localparam int STAGES = 2;
   localparam int DW     = LANE_W + (LANE_W - 1) * (STAGES - 1);

   typedef struct {
      logic [DW-1:0] d;
      logic          chk;
      logic          pin;
      logic          e_out;
      logic          e_oe;
      logic          e_err;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_en = 1'b0;
   logic [DW-1:0] data = '0;
   logic          par_in = 1'b0;
   logic          par_out, par_oe, err_n;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   item_t q[$];

   always #10 clk = ~clk;

   parity_io_unit #(.LANE_W(LANE_W), .STAGES(STAGES)) dut_i (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .data(data),
      .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .err_n(err_n)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (data=%h chk=%b pin=%b)",
                  req, act, exp, data, chk_en, par_in);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // driver: applies a vector and queues the reference result
   task automatic drive(input logic [DW-1:0] d, input logic chk, input logic pin,
                        input string tag);
      item_t it;
      @(negedge clk);
      data = d; chk_en = chk; par_in = pin;
      it.d = d; it.chk = chk; it.pin = pin; it.tag = tag;
      it.e_out = ~(^d);
      it.e_oe  = ~chk;
      it.e_err = chk ? ^{d, pin} : 1'b1;
      q.push_back(it);
   endtask

   // monitor: compares in the low phase of the clock
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (!it.chk) begin
               check({"R1 ", it.tag}, par_out, it.e_out);
               check("R2 drive in generate", par_oe, it.e_oe);
               check("R4 no error in generate", err_n, it.e_err);
            end else begin
               check("R3 release in check", par_oe, it.e_oe);
               check({"R5 ", it.tag}, err_n, it.e_err);
            end
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected completion", cycles);
         finish_run();
      end
   end

   initial begin
      // R6: reset holds the pin released and the error line quiet
      data = 17'h1_0000; chk_en = 1'b0;
      repeat (3) @(negedge clk);
      #5;
      check("R6 oe in reset", par_oe, 1'b0);
      check("R6 err in reset", err_n, 1'b1);
      @(negedge clk);
      chk_en = 1'b1; data = '0; par_in = 1'b0;
      #5;
      check("R6 err in reset, check mode", err_n, 1'b1);
      @(negedge clk);
      chk_en = 1'b0; rst_n = 1'b1;
      #5;
      check("R6 oe before first edge", par_oe, 1'b0);
      @(negedge clk);
      #5;
      check("R2 oe after first edge", par_oe, 1'b1);

      // main sweep: all low-lane patterns, both modes, both pin levels
      for (int p = 0; p < 512; p++) begin
         for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 2; b++) begin
               logic [7:0] hi;
               hi = 8'((p * 37 + 11) & 255);
               drive({hi, 9'(p)}, m[0], b[0], "sweep");
            end
         end
      end

      // R7: activity only in the second stage
      for (int h = 0; h < 256; h++) begin
         drive({8'(h), 9'h000}, 1'b0, 1'b0, "R7 upper lane");
         drive({8'(h), 9'h000}, 1'b1, 1'(h & 1), "R7 upper lane check");
      end

      repeat (3) @(negedge clk);

      // R6: reset in mid-run releases the pin at once
      chk_en = 1'b0;
      rst_n = 1'b0;
      #5;
      check("R6 oe on mid-run reset", par_oe, 1'b0);
      check("R6 err on mid-run reset", err_n, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #5;
      check("R2 oe after reset again", par_oe, 1'b1);

      if (q.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL scoreboard: got %0d pending expected 0", q.size());
      end
      finish_run();
   end

endmodule